// File: doc/BRIEF.md
# Programmable Waveform Bus Engine

This block produces the handshake waveform for an external parallel bus from a small table of programmable vectors. Each vector sets the levels of six control lines. It can hold the engine until the synchronized ready inputs meet a condition, and it names the vector that follows. A vector can also pulse a FIFO strobe, which pops a word from an outbound FIFO or pushes a word into an inbound one, and it can bump a 9-bit address counter.

The host fills the table while the engine is idle. It then presents a 32-bit transaction count and pulses start. The engine runs from vector 0. A vector marked as the end of a transaction decrements the count and either loops back to vector 0 or, once the count is spent, returns to idle with a one-cycle done pulse. The remaining count can be read at any time. If a vector asks for a FIFO move that the FIFO cannot take, the engine waits on that vector until it can.

Top module: `wavebus_engine`

## Requirements
- R1: While reset is high and in the cycle after it, busy_o, done_o, fifo_rd_o and fifo_wr_o are 0, addr_o and remain_o are 0, and ctl_o equals the IDLE_CTL parameter (default 0).
- R2: A table write with tbl_we high stores tbl_wdata in the entry at tbl_addr (0 to 6). A write to address 7 is ignored. Word fields: ctl [5:0], ready mask [11:6], combine [12] (0 = all masked inputs, 1 = any masked input), expected level [13], next index [16:14], FIFO move [17], FIFO direction [18] (0 = pop, 1 = push), address increment [19], end of transaction [20].
- R3: A start pulse seen while idle with a nonzero xfer_count gives, one cycle later, busy_o = 1, remain_o = xfer_count, addr_o = 0 and ctl_o = the ctl field of entry 0.
- R4: While busy, ctl_o shows the ctl field of the current vector. After each advance it moves to the next vector's ctl one cycle later, so it can change on every clock.
- R5: Ready inputs pass through two flops before evaluation. A vector with a zero mask advances after one cycle. Otherwise it advances only when every masked bit (combine 0) or at least one masked bit (combine 1) equals the expected level.
- R6: A vector with the FIFO move bit set does not advance while fifo_empty (pop) or fifo_full (push) is high. In the cycle after it advances, fifo_rd_o (pop) or fifo_wr_o (push) is high for one cycle, and the two strobes are never high together.
- R7: Each advance of a vector with the increment bit set adds one to addr_o, wrapping from 511 to 0. addr_o is otherwise held.
- R8: Advancing an end-of-transaction vector decrements remain_o by one. If the result is nonzero the next vector is entry 0. If it is zero, busy_o falls and done_o is high for one cycle in that same cycle.
- R9: A start pulse while busy_o is high is ignored. The run, including remain_o, continues as if no pulse had come.
- R10: A start pulse while idle with xfer_count = 0 gives done_o = 1 one cycle later, with busy_o staying 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Vector table write enable |
| tbl_addr | input | 3 | Vector table write index |
| tbl_wdata | input | 21 | Vector word to write |
| start | input | 1 | Start pulse |
| xfer_count | input | 32 | Transaction count loaded on start |
| rdy_i | input | 6 | Asynchronous ready inputs |
| fifo_empty | input | 1 | Outbound FIFO has no word |
| fifo_full | input | 1 | Inbound FIFO has no room |
| ctl_o | output | 6 | Control line levels |
| addr_o | output | 9 | Address counter |
| fifo_rd_o | output | 1 | Pop strobe |
| fifo_wr_o | output | 1 | Push strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run-complete pulse |
| remain_o | output | 32 | Transactions still to run |

## Verification
On every cycle the assertions check the following: a strobe never follows a cycle in which its FIFO flag was blocking, the two strobes never coincide, the address and the remaining count each step by at most one while busy, and done coincides with busy falling. They also check the one-cycle responses to an accepted start and to a zero-count start. Whether the ready combinations, the expected levels, the two-flop latency, the loop back to vector 0 and an ignored start while busy give the right waveform shows only in the bench. There, a behavioural model driven by random ready and FIFO flag patterns is compared with every output on every clock.

// File: rtl/wavebus_pkg.sv
package wavebus_pkg;
  localparam int CTL_W = 6;
  localparam int RDY_W = 6;
  localparam int IDX_W = 3;
  localparam int NUM_SLOTS = 2 ** IDX_W;
  localparam int VEC_W = CTL_W + RDY_W + 2 + IDX_W + 4;

  typedef struct packed {
    logic              eot;
    logic              inc;
    logic              dir;
    logic              adv;
    logic [IDX_W-1:0]  nxt;
    logic              lvl;
    logic              any;
    logic [RDY_W-1:0]  mask;
    logic [CTL_W-1:0]  ctl;
  } vec_t;
endpackage

// File: rtl/wb_rdy_sync.sv
module wb_rdy_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wb_vec_table.sv
module wb_vec_table
  import wavebus_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  vec_t             wdata,
  input  logic [IDX_W-1:0] cur_idx,
  output vec_t             cur_vec,
  input  logic [IDX_W-1:0] nx_idx,
  output logic [CTL_W-1:0] nx_ctl
);
  localparam logic [IDX_W-1:0] IDLE_SLOT = IDX_W'(NUM_SLOTS - 1);

  vec_t mem [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (we && (waddr != IDLE_SLOT)) mem[waddr] <= wdata;
  end

  assign cur_vec = mem[cur_idx];
  assign nx_ctl  = mem[nx_idx].ctl;
endmodule

// File: rtl/wb_xfer_count.sv
module wb_xfer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] value,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign value = cnt_q;
  assign last  = (cnt_q == ONE);
endmodule

// File: rtl/wb_sequencer.sv
module wb_sequencer
  import wavebus_pkg::*;
#(
  parameter int               ADDR_W   = 9,
  parameter int               CNT_W    = 32,
  parameter logic [CTL_W-1:0] IDLE_CTL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic [RDY_W-1:0]  rdy_s,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  vec_t              cur_vec,
  input  logic [CTL_W-1:0]  nx_ctl,
  input  logic              cnt_last,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  nx_idx,
  output logic              cnt_load,
  output logic              cnt_dec,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fifo_rd_o,
  output logic              fifo_wr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0]  IDLE_SLOT = IDX_W'(NUM_SLOTS - 1);
  localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CTL_W-1:0]  ctl_q;
  logic              rd_q, wr_q, done_q;

  logic [RDY_W-1:0]  hit;
  logic              rdy_ok, fifo_block, go, finishing;
  logic              accept, zero_start;

  always_comb begin
    hit        = ~(rdy_s ^ {RDY_W{cur_vec.lvl}}) & cur_vec.mask;
    if (cur_vec.mask == '0)  rdy_ok = 1'b1;
    else if (cur_vec.any)    rdy_ok = |hit;
    else                     rdy_ok = (hit == cur_vec.mask);
    fifo_block = cur_vec.adv & (cur_vec.dir ? fifo_full : fifo_empty);
    go         = busy_q & rdy_ok & ~fifo_block;
    finishing  = go & cur_vec.eot & cnt_last;
    accept     = ~busy_q & start & (xfer_count != '0);
    zero_start = ~busy_q & start & (xfer_count == '0);
  end

  always_comb begin
    if (!busy_q || cur_vec.eot || cur_vec.nxt == IDLE_SLOT) nx_idx = '0;
    else                                                     nx_idx = cur_vec.nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      addr_q <= '0;
      ctl_q  <= IDLE_CTL;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rd_q   <= go & cur_vec.adv & ~cur_vec.dir;
      wr_q   <= go & cur_vec.adv & cur_vec.dir;
      done_q <= zero_start | finishing;
      if (accept) begin
        busy_q <= 1'b1;
        cur_q  <= '0;
        addr_q <= '0;
        ctl_q  <= nx_ctl;
      end else if (go) begin
        if (cur_vec.inc) addr_q <= addr_q + ADDR_ONE;
        if (finishing) begin
          busy_q <= 1'b0;
          ctl_q  <= IDLE_CTL;
        end else begin
          cur_q <= nx_idx;
          ctl_q <= nx_ctl;
        end
      end else if (busy_q) begin
        ctl_q <= cur_vec.ctl;
      end
    end
  end

  assign cur_idx   = cur_q;
  assign cnt_load  = accept;
  assign cnt_dec   = go & cur_vec.eot;
  assign ctl_o     = ctl_q;
  assign addr_o    = addr_q;
  assign fifo_rd_o = rd_q;
  assign fifo_wr_o = wr_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
endmodule

// File: rtl/wavebus_engine.sv
module wavebus_engine
  import wavebus_pkg::*;
#(
  parameter int               ADDR_W      = 9,
  parameter int               CNT_W       = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CTL_W-1:0] IDLE_CTL    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [VEC_W-1:0]  tbl_wdata,
  input  logic              start,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic [RDY_W-1:0]  rdy_i,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fifo_rd_o,
  output logic              fifo_wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  remain_o
);
  logic [RDY_W-1:0] rdy_s;
  vec_t             cur_vec;
  logic [CTL_W-1:0] nx_ctl;
  logic [IDX_W-1:0] cur_idx, nx_idx;
  logic             cnt_load, cnt_dec, cnt_last;

  wb_rdy_sync #(.WIDTH(RDY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rdy_i), .q(rdy_s)
  );

  wb_vec_table u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(vec_t'(tbl_wdata)),
    .cur_idx(cur_idx), .cur_vec(cur_vec), .nx_idx(nx_idx), .nx_ctl(nx_ctl)
  );

  wb_xfer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(xfer_count),
    .dec(cnt_dec), .value(remain_o), .last(cnt_last)
  );

  wb_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDLE_CTL(IDLE_CTL)) u_seq (
    .clk(clk), .rst(rst), .start(start), .xfer_count(xfer_count),
    .rdy_s(rdy_s), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .cur_vec(cur_vec), .nx_ctl(nx_ctl), .cnt_last(cnt_last),
    .cur_idx(cur_idx), .nx_idx(nx_idx), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .ctl_o(ctl_o), .addr_o(addr_o), .fifo_rd_o(fifo_rd_o), .fifo_wr_o(fifo_wr_o),
    .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/wavebus_engine_chk.sv
module wavebus_engine_chk #(
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  xfer_count,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic [ADDR_W-1:0] addr_o,
  input logic              fifo_rd_o,
  input logic              fifo_wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  remain_o
);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_rd_o, fifo_wr_o}));

  assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_o |-> $past(!fifo_empty));

  assert_push_needs_room_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_o |-> $past(!fifo_full));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |->
      (addr_o == $past(addr_o) || addr_o == ADDR_W'($past(addr_o) + 1'b1)));

  assert_remain_step_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |->
      (remain_o == $past(remain_o) || remain_o == CNT_W'($past(remain_o) - 1'b1)));

  assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_fall_gives_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start && xfer_count != '0) |=> (busy_o && remain_o == $past(xfer_count)));

  assert_zero_start_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start && xfer_count == '0) |=> (done_o && !busy_o));
endmodule

bind wavebus_engine wavebus_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .xfer_count(xfer_count),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .addr_o(addr_o),
  .fifo_rd_o(fifo_rd_o), .fifo_wr_o(fifo_wr_o), .busy_o(busy_o),
  .done_o(done_o), .remain_o(remain_o)
);

// File: tb/tb_wavebus_engine.sv
module tb_wavebus_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_addr = '0;
  logic [20:0] tbl_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] xfer_count = '0;
  logic [5:0]  rdy_i = '0;
  logic        fifo_empty = 1'b0;
  logic        fifo_full = 1'b0;
  logic [5:0]  ctl_o;
  logic [8:0]  addr_o;
  logic        fifo_rd_o, fifo_wr_o, busy_o, done_o;
  logic [31:0] remain_o;

  wavebus_engine dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .xfer_count(xfer_count),
    .rdy_i(rdy_i), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ctl_o(ctl_o), .addr_o(addr_o), .fifo_rd_o(fifo_rd_o),
    .fifo_wr_o(fifo_wr_o), .busy_o(busy_o), .done_o(done_o), .remain_o(remain_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit random_in = 1'b0;
  bit compare_on = 1'b0;
  string scen = "R1";

  // behavioural reference state
  int          m_tbl [8];
  bit          m_busy;
  int          m_cur;
  longint      m_rem;
  int          m_addr;
  int          m_ctl;
  bit          m_rd, m_wr, m_done;
  bit [5:0]    m_s1, m_s2;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (scenario %s) actual=%0d expected=%0d at cycle %0d",
               tag, scen, act, exp, cycles);
    end
  endtask

  function automatic int mkvec(int ctl, int mask, int any, int lvl, int nxt,
                               int adv, int dir, int inc, int eot);
    return ctl | (mask << 6) | (any << 12) | (lvl << 13) | (nxt << 14) |
           (adv << 17) | (dir << 18) | (inc << 19) | (eot << 20);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cur = 0; m_rem = 0; m_addr = 0; m_ctl = 0;
      m_rd = 0; m_wr = 0; m_done = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int w, mask, lvl;
      bit any_hit, all_hit, ok, blocked;
      m_rd = 0; m_wr = 0; m_done = 0;
      if (!m_busy) begin
        if (start) begin
          if (xfer_count == 0) m_done = 1;
          else begin
            m_busy = 1; m_cur = 0; m_rem = xfer_count; m_addr = 0;
            m_ctl = m_tbl[0] & 63;
          end
        end
      end else begin
        w = m_tbl[m_cur];
        mask = (w >> 6) & 63;
        lvl = (w >> 13) & 1;
        any_hit = 0; all_hit = 1;
        for (int i = 0; i < 6; i++)
          if (mask[i]) begin
            if (m_s2[i] == lvl[0]) any_hit = 1; else all_hit = 0;
          end
        ok = (mask == 0) ? 1'b1 : (((w >> 12) & 1) != 0 ? any_hit : all_hit);
        blocked = ((w >> 17) & 1) != 0 && ((((w >> 18) & 1) != 0) ? fifo_full : fifo_empty);
        if (ok && !blocked) begin
          if (((w >> 17) & 1) != 0) begin
            if (((w >> 18) & 1) != 0) m_wr = 1; else m_rd = 1;
          end
          if (((w >> 19) & 1) != 0) m_addr = (m_addr + 1) % 512;
          if (((w >> 20) & 1) != 0) begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin m_busy = 0; m_done = 1; m_ctl = 0; end
            else begin m_cur = 0; m_ctl = m_tbl[0] & 63; end
          end else begin
            m_cur = (w >> 14) & 7;
            if (m_cur == 7) m_cur = 0;
            m_ctl = m_tbl[m_cur] & 63;
          end
        end else begin
          m_ctl = w & 63;
        end
      end
      m_s2 = m_s1;
      m_s1 = rdy_i;
      if (tbl_we && tbl_addr != 7) m_tbl[tbl_addr] = tbl_wdata;
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      check("R4 ctl_o", ctl_o, m_ctl);
      check("R7 addr_o", addr_o, m_addr);
      check("R6 fifo_rd_o", fifo_rd_o, m_rd);
      check("R6 fifo_wr_o", fifo_wr_o, m_wr);
      check("R3 busy_o", busy_o, m_busy);
      check("R8 done_o", done_o, m_done);
      check("R8 remain_o", remain_o, m_rem);
    end
    if (random_in) begin
      rdy_i      <= 6'($urandom);
      fifo_empty <= ($urandom % 4) == 0;
      fifo_full  <= ($urandom % 4) == 0;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog (scenario %s) actual=%0d expected<=%0d", scen, cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic wr_vec(int idx, int w);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 3'(idx); tbl_wdata = 21'(w);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic pulse_start(longint cnt);
    @(negedge clk);
    start = 1; xfer_count = 32'(cnt);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy_o", busy_o, 0);
    check("R1 done_o", done_o, 0);
    check("R1 ctl_o", ctl_o, 0);
    rst = 0;
    @(negedge clk);
    check("R1 addr_o", addr_o, 0);
    check("R1 remain_o", remain_o, 0);
    check("R1 strobes", {fifo_rd_o, fifo_wr_o}, 0);
    compare_on = 1;

    // R2 / R5 / R6: pop, wait on rdy0 high (all), increment, end of transaction
    scen = "R2";
    wr_vec(0, mkvec(6'h01, 0, 0, 0, 1, 1, 0, 0, 0));
    wr_vec(1, mkvec(6'h03, 6'b000001, 0, 1, 2, 0, 0, 1, 0));
    wr_vec(2, mkvec(6'h20, 6'b001100, 0, 0, 0, 0, 0, 0, 1));
    wr_vec(7, mkvec(6'h3f, 0, 0, 0, 0, 0, 0, 0, 1));
    random_in = 1;
    pulse_start(5);
    check("R2 ctl_o first vector", ctl_o, 6'h01);
    check("R3 remain_o loaded", remain_o, 5);
    scen = "R5";
    wait_done();
    check("R8 remain_o spent", remain_o, 0);

    // R5 any-of with expected level 0, push direction
    scen = "R5";
    wr_vec(0, mkvec(6'h11, 6'b000110, 1, 0, 3, 1, 1, 1, 0));
    wr_vec(3, mkvec(6'h22, 6'b110000, 1, 1, 4, 0, 0, 0, 0));
    wr_vec(4, mkvec(6'h04, 0, 0, 0, 0, 1, 0, 1, 1));
    pulse_start(7);
    wait_done();

    // R10 zero count
    scen = "R10";
    @(negedge clk);
    start = 1; xfer_count = 0;
    @(negedge clk);
    start = 0;
    check("R10 done_o", done_o, 1);
    check("R10 busy_o", busy_o, 0);

    // R9 start while busy
    scen = "R9";
    pulse_start(4);
    repeat (2) @(negedge clk);
    start = 1; xfer_count = 1000;
    @(negedge clk);
    start = 0;
    check("R9 remain_o not reloaded", remain_o < 5, 1);
    wait_done();

    // R7 address wrap and R8 loop over 600 one-vector transactions
    scen = "R7";
    random_in = 0;
    fifo_empty = 0; fifo_full = 0;
    wr_vec(0, mkvec(6'h09, 0, 0, 0, 5, 0, 0, 1, 1));
    pulse_start(600);
    wait_done();
    check("R7 addr_o wrapped", addr_o, 88);

    // R6 pop stalls on empty
    scen = "R6";
    wr_vec(0, mkvec(6'h02, 0, 0, 0, 0, 1, 0, 0, 1));
    fifo_empty = 1;
    pulse_start(2);
    repeat (5) @(negedge clk);
    check("R6 stalled remain_o", remain_o, 2);
    check("R6 no pop while empty", fifo_rd_o, 0);
    fifo_empty = 0;
    wait_done();

    compare_on = 0;
    finish_run();
  end
endmodule